// File: doc/BRIEF.md
# Rest-of-Quad Vector Load/Store Unit

This unit moves the partial tail of a 16-byte quadword between one 128-bit vector register and a byte-wide data memory. A caller pulses `start` with a base value, a signed 7-bit offset counted in quadwords, an element index and a register number. The unit then reads the register, transfers one byte per clock through the memory port, and pulses `done` when it has finished. A load also writes the register back. The memory address always starts at the 16-byte boundary below the effective address and counts upward.

The misalignment `a = EA mod 16` and the element index `e` set which lanes take part. A load fills the last `a - e` lanes of the register from the first bytes of the aligned block. A store writes the first `a` bytes of the block from lanes taken in rotated order. Both forms wrap the lane index across the quad boundary. If nothing is to be moved, the unit makes no memory or register access and reports completion on the next cycle.

Top module: `vrq_ldst`

## Requirements
- R1: The effective address EA is `base + (sign_extend(offset) << 4)`. Every transfer uses memory addresses that start at EA with bits [3:0] cleared and rise by one per byte.
- R2: On a load (`is_store`=0) with a = EA[3:0] and e = `elem`, n = a − e bytes are moved when a > e, and none otherwise. Memory byte k (k = 0..n−1) goes into lane 16 − n + k. Lane L occupies bits [127−8L : 120−8L], so lane 0 is the most significant byte.
- R3: A load with n > 0 writes the register selected by `vreg` exactly once, through `vrf_wr_*`. The written value is the register's previous contents with only the lanes named in R2 replaced.
- R4: On a store (`is_store`=1), a bytes are written. Byte k (k = 0..a−1) goes to aligned address + k and holds lane (e + k − a) mod 16 of the register selected by `vreg`.
- R5: When there are no bytes to move (a store with a = 0, or a load with a ≤ e), the unit makes no memory write and no register write, and `done` rises at the edge that samples `start`.
- R6: Exactly one byte moves per cycle. With n > 0 bytes, `done` rises n+2 clock edges after the start edge for a store, and n+3 edges after it for a load. The start edge is counted as the first.
- R7: `start` is ignored while `busy` is high. It causes no extra access and leaves the completion time unchanged.
- R8: `done` is a pulse of one cycle, and it is high only while `busy` is low.
- R9: A store never asserts `vrf_wr_en`, and a load never asserts `mem_we`.
- R10: After reset, `busy`, `done`, `mem_we` and `vrf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| is_store | input | 1 | 1 = store register to memory, 0 = load |
| base | input | 32 | Base address value |
| offset | input | 7 | Signed offset in quadwords |
| elem | input | 4 | Element (byte lane) index |
| vreg | input | 5 | Vector register number |
| vrf_rd_idx | output | 5 | Register file read index |
| vrf_rd_data | input | 128 | Register file read data (combinational) |
| vrf_wr_en | output | 1 | Register file write enable |
| vrf_wr_idx | output | 5 | Register file write index |
| vrf_wr_data | output | 128 | Register file write data |
| mem_addr | output | 32 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte (combinational) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the lane wrap at the quad boundary with a store where a = 15 and e = 3. A design that used lane e + k without the rotation would write the wrong bytes there. Load cases cover a > e, a = e and a = 15, e = 0. These catch an off-by-one start lane, which would shift every loaded byte, and a missing zero-length guard, which would hang or write the register. A negative offset and a nonzero offset check the sign extension and the scale by 16; an error there shows up in the first memory address. A second `start` sent mid-operation would, if it were accepted, add writes or change the completion time.

// File: rtl/vrq_pkg.sv
package vrq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MOVE  = 2'd2,
        ST_WB    = 2'd3
    } vrq_state_e;

endpackage

// File: rtl/vrq_addr_gen.sv
module vrq_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 7,
    parameter int ELEM_W = 4,
    localparam int CNT_W = ELEM_W + 1
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [ELEM_W-1:0] elem_i,
    input  logic              store_i,
    output logic [ADDR_W-1:0] aligned_o,
    output logic [ELEM_W-1:0] first_lane_o,
    output logic [CNT_W-1:0]  count_o
);
    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] eff;
    logic [ELEM_W-1:0] mis;

    always_comb begin
        ofs_ext      = {{(ADDR_W-OFS_W){offset_i[OFS_W-1]}}, offset_i};
        eff          = base_i + (ofs_ext << ELEM_W);
        mis          = eff[ELEM_W-1:0];
        aligned_o    = {eff[ADDR_W-1:ELEM_W], {ELEM_W{1'b0}}};
        // Same start lane for both directions: (e - a) mod lane count
        first_lane_o = elem_i - mis;
        if (store_i)
            count_o = CNT_W'(mis);
        else if (mis > elem_i)
            count_o = CNT_W'(mis - elem_i);
        else
            count_o = '0;
    end
endmodule

// File: rtl/vrq_lane_pick.sv
module vrq_lane_pick #(
    parameter int ELEM_W = 4,
    parameter int BYTE_W = 8,
    localparam int LANES = 1 << ELEM_W,
    localparam int VEC_W = LANES * BYTE_W
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [ELEM_W-1:0] lane_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lane_a [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_a[g] = vec_i[VEC_W-1-g*BYTE_W -: BYTE_W];
    end

    assign byte_o = lane_a[lane_i];
endmodule

// File: rtl/vrq_lane_merge.sv
module vrq_lane_merge #(
    parameter int ELEM_W = 4,
    parameter int BYTE_W = 8,
    localparam int LANES = 1 << ELEM_W,
    localparam int VEC_W = LANES * BYTE_W
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [ELEM_W-1:0] lane_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              en_i,
    output logic [VEC_W-1:0]  vec_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign vec_o[VEC_W-1-g*BYTE_W -: BYTE_W] =
            (en_i && (lane_i == ELEM_W'(g))) ? byte_i
                                             : vec_i[VEC_W-1-g*BYTE_W -: BYTE_W];
    end
endmodule

// File: rtl/vrq_ldst.sv
module vrq_ldst
    import vrq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 7,
    parameter int ELEM_W = 4,
    parameter int BYTE_W = 8,
    parameter int VREG_W = 5,
    localparam int LANES = 1 << ELEM_W,
    localparam int VEC_W = LANES * BYTE_W,
    localparam int CNT_W = ELEM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_store,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  offset,
    input  logic [ELEM_W-1:0] elem,
    input  logic [VREG_W-1:0] vreg,
    output logic [VREG_W-1:0] vrf_rd_idx,
    input  logic [VEC_W-1:0]  vrf_rd_data,
    output logic              vrf_wr_en,
    output logic [VREG_W-1:0] vrf_wr_idx,
    output logic [VEC_W-1:0]  vrf_wr_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        vrq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [ELEM_W-1:0] lane;
        logic              store;
        logic [VREG_W-1:0] vreg;
        logic [VEC_W-1:0]  data;
        logic              done;
    } vrq_regs_t;

    vrq_regs_t q, d;

    logic [ADDR_W-1:0] ag_aligned;
    logic [ELEM_W-1:0] ag_first;
    logic [CNT_W-1:0]  ag_count;
    logic [VEC_W-1:0]  merged;
    logic [BYTE_W-1:0] picked;
    logic              moving;
    logic              op_store;

    assign moving   = (q.st == ST_MOVE);
    assign op_store = q.store;

    vrq_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .ELEM_W(ELEM_W)) u_agen (
        .base_i      (base),
        .offset_i    (offset),
        .elem_i      (elem),
        .store_i     (is_store),
        .aligned_o   (ag_aligned),
        .first_lane_o(ag_first),
        .count_o     (ag_count)
    );

    vrq_lane_pick #(.ELEM_W(ELEM_W), .BYTE_W(BYTE_W)) u_pick (
        .vec_i (q.data),
        .lane_i(q.lane),
        .byte_o(picked)
    );

    vrq_lane_merge #(.ELEM_W(ELEM_W), .BYTE_W(BYTE_W)) u_merge (
        .vec_i (q.data),
        .lane_i(q.lane),
        .byte_i(mem_rdata),
        .en_i  (moving && !q.store),
        .vec_o (merged)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.addr  = ag_aligned;
                    d.cnt   = ag_count;
                    d.lane  = ag_first;
                    d.store = is_store;
                    d.vreg  = vreg;
                    if (ag_count == '0)
                        d.done = 1'b1;
                    else
                        d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                d.data = vrf_rd_data;
                d.st   = ST_MOVE;
            end
            ST_MOVE: begin
                d.data = merged;
                d.addr = q.addr + ADDR_W'(1);
                d.lane = q.lane + ELEM_W'(1);
                d.cnt  = q.cnt - CNT_W'(1);
                if (q.cnt == CNT_W'(1)) begin
                    if (q.store) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_WB;
                    end
                end
            end
            ST_WB: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vrf_rd_idx  = q.vreg;
    assign vrf_wr_en   = (q.st == ST_WB);
    assign vrf_wr_idx  = q.vreg;
    assign vrf_wr_data = q.data;
    assign mem_addr    = q.addr;
    assign mem_we      = moving && q.store;
    assign mem_wdata   = picked;
    assign busy        = (q.st != ST_IDLE);
    assign done        = q.done;
endmodule

// File: rtl/vrq_ldst_chk.sv
module vrq_ldst_chk #(
    parameter int ADDR_W = 32,
    parameter int ELEM_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic              vrf_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              moving,
    input logic              op_store
);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_store_no_vrf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vrf_wr_en |-> !op_store);

    p_load_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (op_store && busy));

    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && $past(moving)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    p_first_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(moving) |-> (mem_addr[ELEM_W-1:0] == '0));

    p_wb_after_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vrf_wr_en) |-> $past(moving));
endmodule

bind vrq_ldst vrq_ldst_chk #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .vrf_wr_en(vrf_wr_en),
    .mem_addr (mem_addr),
    .moving   (moving),
    .op_store (op_store)
);

// File: tb/tb_vrq_ldst.sv
`timescale 1ns/1ps
module tb_vrq_ldst;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_store = 1'b0;
    logic [31:0]  base = '0;
    logic [6:0]   offset = '0;
    logic [3:0]   elem = '0;
    logic [4:0]   vreg = '0;
    logic [4:0]   vrf_rd_idx;
    logic [127:0] vrf_rd_data;
    logic         vrf_wr_en;
    logic [4:0]   vrf_wr_idx;
    logic [127:0] vrf_wr_data;
    logic [31:0]  mem_addr;
    logic         mem_we;
    logic [7:0]   mem_wdata;
    logic [7:0]   mem_rdata;
    logic         busy;
    logic         done;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        bit           is_vrf;
        logic [31:0]  addr;
        logic [127:0] data;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [127:0] reg_val(input logic [4:0] r);
        logic [127:0] v;
        for (int l = 0; l < 16; l++)
            v[127-8*l -: 8] = 8'(r * 16 + l) ^ 8'h96;
        return v;
    endfunction

    assign mem_rdata   = mem_byte(mem_addr);
    assign vrf_rd_data = reg_val(vrf_rd_idx);

    vrq_ldst dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .base(base), .offset(offset), .elem(elem), .vreg(vreg),
        .vrf_rd_idx(vrf_rd_idx), .vrf_rd_data(vrf_rd_data),
        .vrf_wr_en(vrf_wr_en), .vrf_wr_idx(vrf_wr_idx), .vrf_wr_data(vrf_wr_data),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected writes and compares them
    always @(negedge clk) begin
        exp_t it;
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0 || exp_q[0].is_vrf) begin
                check(1'b0, "R5/R9", "unexpected memory write", {96'b0, mem_addr}, '0);
            end else begin
                it = exp_q.pop_front();
                check(mem_addr == it.addr, "R1", "store address", {96'b0, mem_addr}, {96'b0, it.addr});
                check(mem_wdata == it.data[7:0], "R4", "store byte", {120'b0, mem_wdata}, it.data);
            end
        end
        if (rst_n && vrf_wr_en) begin
            if (exp_q.size() == 0 || !exp_q[0].is_vrf) begin
                check(1'b0, "R5/R9", "unexpected register write", {123'b0, vrf_wr_idx}, '0);
            end else begin
                it = exp_q.pop_front();
                check(vrf_wr_idx == it.addr[4:0], "R3", "writeback index", {123'b0, vrf_wr_idx}, it.data);
                check(vrf_wr_data == it.data, "R2", "merged register", vrf_wr_data, it.data);
            end
        end
    end

    // Driver: computes expected items from the requirements, runs one op
    task automatic run_op(input bit st, input logic [31:0] b, input logic [6:0] o,
                          input logic [3:0] e, input logic [4:0] r, input bit poke);
        logic [31:0]  ea;
        logic [31:0]  al;
        logic [127:0] v;
        int a, n, lat, exp_lat, lane;
        exp_t it;
        ea = b + ({{25{o[6]}}, o} << 4);
        al = {ea[31:4], 4'b0};
        a  = int'(ea[3:0]);
        v  = reg_val(r);
        if (st) n = a;
        else    n = (a > int'(e)) ? a - int'(e) : 0;
        if (st) begin
            for (int k = 0; k < n; k++) begin
                lane = (int'(e) + k - a + 16) % 16;
                it.is_vrf = 1'b0;
                it.addr   = al + 32'(k);
                it.data   = {120'b0, v[127-8*lane -: 8]};
                exp_q.push_back(it);
            end
        end else if (n > 0) begin
            for (int k = 0; k < n; k++) begin
                lane = 16 - n + k;
                v[127-8*lane -: 8] = mem_byte(al + 32'(k));
            end
            it.is_vrf = 1'b1;
            it.addr   = {27'b0, r};
            it.data   = v;
            exp_q.push_back(it);
        end
        exp_lat = (n == 0) ? 1 : (st ? n + 2 : n + 3);

        @(posedge clk); #1;
        start = 1'b1; is_store = st; base = b; offset = o; elem = e; vreg = r;
        @(posedge clk); #1;
        start = 1'b0; base = ~b; offset = ~o; elem = ~e; vreg = ~r;
        lat = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2) begin
                start = 1'b1; is_store = ~st; base = 32'h0000_00AF; elem = 4'd0;
            end
            if (poke && lat == 3) start = 1'b0;
            if (done || lat > 60) break;
        end
        check(lat == exp_lat, "R6", "completion latency", 128'(lat), 128'(exp_lat));
        check(exp_q.size() == 0, "R5", "all expected accesses seen", 128'(exp_q.size()), '0);
        exp_q.delete();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!busy && !done, "R7", "idle after completion",
                  {126'b0, busy, done}, '0);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_we && !vrf_wr_en, "R10", "reset outputs",
              {124'b0, busy, done, mem_we, vrf_wr_en}, '0);
        // R4: store a=5 e=0
        run_op(1'b1, 32'h0000_1005, 7'd0, 4'd0, 5'd3, 1'b0);
        // R4: store with lane wrap, a=15 e=3
        run_op(1'b1, 32'h0000_200F, 7'd0, 4'd3, 5'd7, 1'b0);
        // R5: store with a=0
        run_op(1'b1, 32'h0000_3000, 7'd2, 4'd9, 5'd1, 1'b0);
        // R2 R3: load a=9 e=2
        run_op(1'b0, 32'h0000_4009, 7'd0, 4'd2, 5'd12, 1'b0);
        // R5: load a=e
        run_op(1'b0, 32'h0000_5003, 7'd0, 4'd3, 5'd4, 1'b0);
        // R2: load a=15 e=0
        run_op(1'b0, 32'h0000_600F, 7'd0, 4'd0, 5'd31, 1'b0);
        // R1: negative offset, store
        run_op(1'b1, 32'h0000_2008, 7'h7F, 4'd1, 5'd9, 1'b0);
        // R1: positive offset, load
        run_op(1'b0, 32'h0000_7004, 7'd3, 4'd1, 5'd20, 1'b0);
        // R7: start pulses while busy
        run_op(1'b1, 32'h0000_8006, 7'd0, 4'd2, 5'd5, 1'b1);
        run_op(1'b0, 32'h0000_900C, 7'd0, 4'd4, 5'd6, 1'b1);
        // R6 R9: single-byte store
        run_op(1'b1, 32'h0000_A001, 7'd0, 4'd15, 5'd2, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule